// File: doc/BRIEF.md
# Merged Sharpen/Clamp T-Kernel Pre-Filter

This block filters 8-bit pixels in a single pass, with a sharpening term and an anti-alias clamp merged into one four-tap kernel. A window supplier presents two adjacent image rows, row n above and row n+1 below, and three columns per output lane. Each accepted window gives two filtered pixels per lane. The row-n result uses a T-shaped kernel: the centre, its two horizontal neighbours and the pixel directly below. The row-n+1 result uses the mirrored shape, with the pixel directly above in place of the one below. Both results are computed in the same cycle.

The kernel has no multipliers. Each coefficient multiple is formed by a shift-and-add unit, which adds shifted copies of the pixel under control of the coefficient's bits. The kernel gain is a power of two, so normalisation is an arithmetic right shift. A two-bit select picks the sharp/clamp pair and the shift from a four-row constant table. The select is captured only when a frame begins. The result is saturated to 0..255 and appears two cycles after the window, marked by a travelling valid flag.

Top module: `tkfilt_top`

## Requirements
- R1: While reset is asserted and after its release, `valid_out` is 0 and `pix_out` is 0 until the first filtered result arrives.
- R2: For each lane L, the row-n result takes centre c = window[row 0][col L+1], sides a = [row 0][col L], b = [row 0][col L+2], and vertical v = [row 1][col L+1]. The result is clamp((Wc·c − d·(a+b) − e·v) >>> SH, 0, 255), where d = S−C, e = S−C−1 and Wc = 2^SH + 2d + e. Pixel (row r, col k) sits at `win_in` bits [(r·(LANES+2)+k)·8 +: 8]. The row-n result for lane L sits at `pix_out` bits [L·8 +: 8].
- R3: The row-n+1 result uses the mirrored kernel with the same formula: centre [row 1][col L+1], sides [row 1][col L] and [row 1][col L+2], and vertical [row 0][col L+1]. It is placed at `pix_out` bits [(LANES+L)·8 +: 8].
- R4: `sel_in` values 0, 1, 2 and 3 select (S, C, SH) = (4,2,3), (6,3,4), (10,5,5) and (3,1,2), giving kernel gains of 8, 16, 32 and 4.
- R5: When `frame_start` is high, the `sel_in` value on that cycle is latched. It applies to any window accepted in that same cycle and to all later windows. Changes on `sel_in` without `frame_start` have no effect. After reset the latched select is 0.
- R6: Normalisation rounds toward minus infinity (arithmetic shift). Sums below 0 give 0, and sums above 255 give 255.
- R7: `valid_out` is high exactly two cycles after each cycle with `valid_in` high, and at no other time. Back-to-back windows give back-to-back results.
- R8: `pix_out` changes only in a cycle where `valid_out` is high. Otherwise it holds its last value, whatever happens on `win_in`.
- R9: A window whose six pixels for a lane are all equal to x gives x for both of that lane's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Latches `sel_in` this cycle |
| sel_in | input | 2 | Sharp/clamp table select |
| valid_in | input | 1 | Window on `win_in` is valid |
| win_in | input | 2·(LANES+2)·8 | Two-row source window, row-major |
| valid_out | output | 1 | Filtered pixels valid |
| pix_out | output | 2·LANES·8 | Row-n results, then row-n+1 results |

## Verification
Every cycle, the assertions check the two-cycle valid latency and that the output holds between results. They also check that the latched select moves only after a frame-start pulse, and that a flat window passes through unchanged. The exact coefficient arithmetic needs the bench's behavioural reference model. So do the floor behaviour of the shift, saturation at both ends, each table row, and the rule that a select change mid-frame is ignored. The model is compared with the outputs on every clock.

// File: rtl/tkf_pkg.sv
package tkf_pkg;
   localparam int COEF_W = 6;
   localparam int SH_W   = 3;

   typedef struct packed {
      logic [COEF_W-1:0] k_ctr;
      logic [COEF_W-1:0] k_side;
      logic [COEF_W-1:0] k_vert;
      logic [SH_W-1:0]   sh;
   } tkf_cfg_t;

   // Derive the shift-add coefficients for one table row.
   function automatic tkf_cfg_t cfg_lookup(input logic [1:0] sel);
      int s_v, c_v, sh_v, d_v, e_v;
      tkf_cfg_t r;
      case (sel)
         2'd0:    begin s_v = 4;  c_v = 2; sh_v = 3; end
         2'd1:    begin s_v = 6;  c_v = 3; sh_v = 4; end
         2'd2:    begin s_v = 10; c_v = 5; sh_v = 5; end
         default: begin s_v = 3;  c_v = 1; sh_v = 2; end
      endcase
      d_v = s_v - c_v;
      e_v = d_v - 1;
      r.k_side = COEF_W'(d_v);
      r.k_vert = COEF_W'(e_v);
      r.k_ctr  = COEF_W'((1 << sh_v) + 2 * d_v + e_v);
      r.sh     = SH_W'(sh_v);
      return r;
   endfunction
endpackage

// File: rtl/tk_rcu.sv
module tk_rcu #(
   parameter int IN_W  = 9,
   parameter int CW    = 6,
   parameter int OUT_W = 15
) (
   input  logic [IN_W-1:0]  x,
   input  logic [CW-1:0]    k,
   output logic [OUT_W-1:0] y
);
   if (OUT_W < IN_W + CW) begin : g_bad_w
      $error("tk_rcu: OUT_W too narrow");
   end

   logic [OUT_W-1:0] part [CW];

   for (genvar b = 0; b < CW; b++) begin : g_term
      assign part[b] = k[b] ? (OUT_W'(x) << b) : '0;
   end

   always_comb begin
      y = '0;
      for (int b = 0; b < CW; b++) y = y + part[b];
   end
endmodule

// File: rtl/tk_half.sv
module tk_half #(
   parameter int PW    = 8,
   parameter int CW    = 6,
   parameter int SHW   = 3,
   parameter int ACC_W = 18
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld1,
   input  logic           ld2,
   input  logic [PW-1:0]  ctr,
   input  logic [PW-1:0]  sa,
   input  logic [PW-1:0]  sb,
   input  logic [PW-1:0]  vt,
   input  logic [CW-1:0]  k_ctr,
   input  logic [CW-1:0]  k_side,
   input  logic [CW-1:0]  k_vert,
   input  logic [SHW-1:0] sh2,
   output logic [PW-1:0]  pix
);
   localparam int PC_W = PW + CW;
   localparam int PS_W = PW + 1 + CW;
   localparam int MAXV = (1 << PW) - 1;

   if (ACC_W < PS_W + 2) begin : g_bad_acc
      $error("tk_half: ACC_W too narrow");
   end

   logic [PW:0]     side_sum;
   logic [PC_W-1:0] m_ctr, r_ctr;
   logic [PS_W-1:0] m_side, r_side;
   logic [PC_W-1:0] m_vert, r_vert;

   assign side_sum = {1'b0, sa} + {1'b0, sb};

   tk_rcu #(.IN_W(PW),   .CW(CW), .OUT_W(PC_W)) u_rc_c (.x(ctr),      .k(k_ctr),  .y(m_ctr));
   tk_rcu #(.IN_W(PW+1), .CW(CW), .OUT_W(PS_W)) u_rc_s (.x(side_sum), .k(k_side), .y(m_side));
   tk_rcu #(.IN_W(PW),   .CW(CW), .OUT_W(PC_W)) u_rc_v (.x(vt),       .k(k_vert), .y(m_vert));

   // stage 1: register the three multiples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_ctr  <= '0;
         r_side <= '0;
         r_vert <= '0;
      end else if (ld1) begin
         r_ctr  <= m_ctr;
         r_side <= m_side;
         r_vert <= m_vert;
      end
   end

   // stage 2: combine, normalise, saturate
   logic signed [ACC_W-1:0] acc, shr;
   logic [PW-1:0]           sat;

   always_comb begin
      acc = $signed(ACC_W'(r_ctr)) - $signed(ACC_W'(r_side)) - $signed(ACC_W'(r_vert));
      shr = acc >>> sh2;
      if (shr < 0)                         sat = '0;
      else if (shr > ACC_W'(MAXV))         sat = PW'(MAXV);
      else                                 sat = shr[PW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pix <= '0;
      else if (ld2) pix <= sat;
   end
endmodule

// File: rtl/tkfilt_top.sv
module tkfilt_top #(
   parameter int PW    = 8,
   parameter int LANES = 1,
   parameter int ACC_W = 18
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frame_start,
   input  logic [1:0]                 sel_in,
   input  logic                       valid_in,
   input  logic [2*(LANES+2)*PW-1:0]  win_in,
   output logic                       valid_out,
   output logic [2*LANES*PW-1:0]      pix_out
);
   import tkf_pkg::*;

   localparam int COLS = LANES + 2;

   if (PW < 2 || PW > 12) begin : g_bad_pw
      $error("tkfilt_top: PW out of range");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("tkfilt_top: LANES must be positive");
   end

   tkf_cfg_t         cfg_q, cfg_eff;
   logic             s1_valid;
   logic [SH_W-1:0]  s1_sh;

   assign cfg_eff = frame_start ? cfg_lookup(sel_in) : cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= cfg_lookup(2'd0);
         s1_valid  <= 1'b0;
         s1_sh     <= '0;
         valid_out <= 1'b0;
      end else begin
         if (frame_start) cfg_q <= cfg_eff;
         s1_valid  <= valid_in;
         if (valid_in) s1_sh <= cfg_eff.sh;
         valid_out <= s1_valid;
      end
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      for (genvar rr = 0; rr < 2; rr++) begin : g_row
         localparam int OWN = rr;
         localparam int OTH = 1 - rr;
         tk_half #(.PW(PW), .CW(COEF_W), .SHW(SH_W), .ACC_W(ACC_W)) u_half (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld1    (valid_in),
            .ld2    (s1_valid),
            .ctr    (win_in[(OWN*COLS + ln + 1)*PW +: PW]),
            .sa     (win_in[(OWN*COLS + ln)*PW +: PW]),
            .sb     (win_in[(OWN*COLS + ln + 2)*PW +: PW]),
            .vt     (win_in[(OTH*COLS + ln + 1)*PW +: PW]),
            .k_ctr  (cfg_eff.k_ctr),
            .k_side (cfg_eff.k_side),
            .k_vert (cfg_eff.k_vert),
            .sh2    (s1_sh),
            .pix    (pix_out[(rr*LANES + ln)*PW +: PW])
         );
      end
   end
endmodule

// File: rtl/tkfilt_chk.sv
module tkfilt_chk #(
   parameter int PW    = 8,
   parameter int LANES = 1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       frame_start,
   input logic                       valid_in,
   input logic [2*(LANES+2)*PW-1:0]  win_in,
   input logic                       valid_out,
   input logic [2*LANES*PW-1:0]      pix_out,
   input tkf_pkg::tkf_cfg_t          cfg_q
);
   localparam int COLS = LANES + 2;

   logic [1:0]    since_rst;
   logic          flat_now, u1, u2;
   logic [PW-1:0] v1, v2;

   always_comb begin
      flat_now = 1'b1;
      for (int r = 0; r < 2; r++)
         for (int c = 0; c < 3; c++)
            if (win_in[(r*COLS + c)*PW +: PW] != win_in[PW-1:0]) flat_now = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= '0;
         u1 <= 1'b0; u2 <= 1'b0;
         v1 <= '0;   v2 <= '0;
      end else begin
         if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
         u1 <= valid_in && flat_now;
         v1 <= win_in[PW-1:0];
         u2 <= u1;
         v2 <= v1;
      end
   end

   // R7: result flag trails the input flag by exactly two cycles
   a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> (valid_out == $past(valid_in, 2)));

   // R8: output holds whenever no result is presented
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && !valid_out) |-> $stable(pix_out));

   // R5: latched selection moves only after a frame-start pulse
   a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && !$past(frame_start)) |-> $stable(cfg_q));

   // R9: flat window on lane 0 reproduces its value on both rows
   a_r9_flat: assert property (@(posedge clk) disable iff (!rst_n)
      (u2 && valid_out) |-> (pix_out[PW-1:0] == v2 && pix_out[LANES*PW +: PW] == v2));
endmodule

bind tkfilt_top tkfilt_chk #(.PW(PW), .LANES(LANES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .valid_in    (valid_in),
   .win_in      (win_in),
   .valid_out   (valid_out),
   .pix_out     (pix_out),
   .cfg_q       (cfg_q)
);

// File: tb/tb_tkfilt_top.sv
module tb_tkfilt_top;
   localparam int PW = 8;
   localparam int LANES = 1;
   localparam int WIN_W = 2*(LANES+2)*PW;
   localparam int OUT_W = 2*LANES*PW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             frame_start = 1'b0;
   logic [1:0]       sel_in = 2'd0;
   logic             valid_in = 1'b0;
   logic [WIN_W-1:0] win_in = '0;
   logic             valid_out;
   logic [OUT_W-1:0] pix_out;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int sent = 0;
   int got = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #2 clk = ~clk;

   tkfilt_top #(.PW(PW), .LANES(LANES), .ACC_W(18)) dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sel_in(sel_in),
      .valid_in(valid_in), .win_in(win_in), .valid_out(valid_out), .pix_out(pix_out));

   // Behavioural reference: filtered value of one output row.
   function automatic int ref_pix(input logic [WIN_W-1:0] w, input int sel, input int row);
      int s, c, sh, d, e, wc, ctr, sa, sb, vt, acc;
      case (sel)
         0: begin s = 4;  c = 2; sh = 3; end
         1: begin s = 6;  c = 3; sh = 4; end
         2: begin s = 10; c = 5; sh = 5; end
         default: begin s = 3; c = 1; sh = 2; end
      endcase
      d = s - c; e = s - c - 1; wc = (1 << sh) + 2*d + e;
      ctr = int'(w[(row*3 + 1)*8 +: 8]);
      sa  = int'(w[(row*3 + 0)*8 +: 8]);
      sb  = int'(w[(row*3 + 2)*8 +: 8]);
      vt  = int'(w[((1-row)*3 + 1)*8 +: 8]);
      acc = wc*ctr - d*(sa + sb) - e*vt;
      acc = acc >>> sh;
      if (acc < 0) acc = 0;
      if (acc > 255) acc = 255;
      return acc;
   endfunction

   int               m_sel;
   logic             p1v, ev;
   logic [OUT_W-1:0] p1d, ep;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sel <= 0; p1v <= 1'b0; p1d <= '0; ev <= 1'b0; ep <= '0;
      end else begin
         int se;
         se = frame_start ? int'(sel_in) : m_sel;
         if (frame_start) m_sel <= int'(sel_in);
         p1v <= valid_in;
         if (valid_in) p1d <= {8'(ref_pix(win_in, se, 1)), 8'(ref_pix(win_in, se, 0))};
         ev <= p1v;
         if (p1v) ep <= p1d;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         cycles++;
         if (valid_out) got++;
         check(valid_out == ev, {cur_req, "/R7 valid"}, int'(valid_out), int'(ev));
         check(pix_out == ep, {cur_req, " pixels"}, int'(pix_out), int'(ep));
      end
   end

   task automatic drive(input bit v, input bit fs, input logic [1:0] s, input logic [WIN_W-1:0] w);
      @(negedge clk);
      valid_in = v; frame_start = fs; sel_in = s; win_in = w;
      if (v) sent++;
   endtask

   function automatic logic [WIN_W-1:0] rnd_win();
      logic [WIN_W-1:0] w;
      for (int i = 0; i < WIN_W/8; i++) w[i*8 +: 8] = 8'($urandom);
      return w;
   endfunction

   function automatic logic [WIN_W-1:0] mk(input int a0, a1, a2, b0, b1, b2);
      return {8'(b2), 8'(b1), 8'(b0), 8'(a2), 8'(a1), 8'(a0)};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(valid_out == 1'b0 && pix_out == '0, "R1 reset", int'(pix_out), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(valid_out == 1'b0 && pix_out == '0, "R1 after release", int'(pix_out), 0);

      // R2/R3/R4: every table row with varied windows
      for (int s = 0; s < 4; s++) begin
         cur_req = (s == 0) ? "R2/R3/R4 sel0" : "R4 sel";
         drive(1'b1, 1'b1, 2'(s), rnd_win());
         for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 2'(s), rnd_win());
      end
      cur_req = "R2/R3 structured";
      drive(1'b1, 1'b1, 2'd1, mk(10, 100, 30, 50, 60, 70));
      drive(1'b1, 1'b0, 2'd1, mk(200, 20, 200, 90, 180, 90));

      // R5: select change without frame start is ignored
      cur_req = "R5";
      drive(1'b1, 1'b1, 2'd2, mk(40, 120, 60, 80, 30, 20));
      for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, 2'(i % 4), rnd_win());
      drive(1'b0, 1'b1, 2'd3, '0);
      for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, 2'd0, rnd_win());

      // R6: saturation and floor behaviour
      cur_req = "R6";
      drive(1'b1, 1'b1, 2'd0, mk(0, 255, 0, 0, 0, 0));
      drive(1'b1, 1'b0, 2'd0, mk(255, 0, 255, 255, 0, 255));
      drive(1'b1, 1'b0, 2'd0, mk(0, 3, 1, 0, 1, 0));
      drive(1'b1, 1'b1, 2'd2, mk(255, 255, 255, 0, 255, 0));

      // R7/R8: sparse windows, idle cycles with noise on the window
      cur_req = "R7/R8";
      for (int i = 0; i < 30; i++) begin
         drive(1'b1, 1'b0, 2'd0, rnd_win());
         drive(1'b0, 1'b0, 2'($urandom), rnd_win());
         if (i % 3 == 0) drive(1'b0, 1'b0, 2'd1, rnd_win());
      end

      // R9: flat windows
      cur_req = "R9";
      for (int s = 0; s < 4; s++) begin
         drive(1'b1, 1'b1, 2'(s), mk(0, 0, 0, 0, 0, 0));
         drive(1'b1, 1'b0, 2'(s), mk(255, 255, 255, 255, 255, 255));
         drive(1'b1, 1'b0, 2'(s), mk(77, 77, 77, 77, 77, 77));
      end

      drive(1'b0, 1'b0, 2'd0, '0);
      repeat (4) @(negedge clk);
      done = 1'b1;
      check(got == sent, "R7 result count", got, sent);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 5000, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule